// File: doc/BRIEF.md
# UART-timed 1-Wire bus master

This block is a 1-Wire bus master that makes every slot on the bus from one 8N1 UART frame rather than from dedicated slot timers. A command port takes one of three requests: a bus reset with presence detection, a single-bit write, or a single-bit read. For each accepted request the block chooses a slow or fast baud rate and a transmit byte, then shifts the frame out on an open-drain line. The low start bit and the zero data bits stretch the bus low time to what the slot needs. The same line is received full duplex. Any device on the bus that holds the line low during the frame changes the received byte.

When the frame is over, the block decodes the echoed byte. For a reset it reports a presence flag, and for a write or read slot it reports the bit seen on the bus. Both results come with a one-cycle done strobe. Both baud rates come from the system clock frequency. The switch between them takes place only between frames, because each accepted command restarts the baud divider.

Top module: `ow_uart_master`

## Requirements
- R1: After a synchronous active-low reset, `cmd_ready` is 1 and both `bus_pull_low` and `done` are 0. Whenever `cmd_ready` is 1 the line is released (`bus_pull_low` = 0).
- R2: A reset command (`cmd_op` = 2'b00) sends byte 0xF0 at the slow rate, least significant bit first, with a low start bit and a high stop bit. `bus_pull_low` is then high for exactly 5 x 16 x DIV_SLOW consecutive cycles, where DIV_SLOW = CLK_HZ / (SLOW_BAUD x 16).
- R3: After a reset slot, `presence` is 1 exactly when the received byte differs from 0xF0, which means a device pulled the line low during the frame.
- R4: A write command (`cmd_op` = 2'b01) with `cmd_bit` = 0 sends byte 0x80 at the fast rate. `bus_pull_low` is then high for exactly 8 x 16 x DIV_FAST cycles, where DIV_FAST = CLK_HZ / (FAST_BAUD x 16).
- R5: A write command with `cmd_bit` = 1, and any read command (`cmd_op` = 2'b10), sends byte 0xFF at the fast rate. `bus_pull_low` is then high for exactly 16 x DIV_FAST cycles, which is the start bit alone.
- R6: After a read or write slot, `result_bit` is 1 exactly when the received byte is 0xFF, and 0 otherwise.
- R7: `done` is a single-cycle pulse. It rises between 10 x 16 x DIV and 10 x 16 x DIV + 3 cycles after the command is accepted, where DIV is the divisor of the slot's rate. `cmd_ready` is low from the cycle after acceptance until `done`, and high again in the `done` cycle.
- R8: A command presented while `cmd_ready` is 0, and a command with the reserved code `cmd_op` = 2'b11, is ignored. No frame starts, no `done` follows, and `cmd_ready` is unaffected.
- R9: The slot timing follows only the current command. A fast slot issued directly after a reset, and a reset issued directly after a fast slot, each keep the exact low times of R2, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 00 reset/presence, 01 write bit, 10 read bit, 11 reserved |
| cmd_bit | input | 1 | Bit value for a write command |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| bus_pull_low | output | 1 | Open-drain drive: 1 pulls the bus low, 0 releases it |
| bus_sense | input | 1 | Sensed bus level (wired-AND of all drivers) |
| done | output | 1 | One-cycle strobe when a slot has completed |
| presence | output | 1 | Device presence from the last reset slot |
| result_bit | output | 1 | Bit seen on the bus in the last read or write slot |

## Verification
The assertions assume that `bus_sense` is never high while the block pulls the line low. They also assume that `cmd_op` and `cmd_bit` carry meaningful values whenever `cmd_valid` is high. The bench's bus model ANDs the master drive with a modelled device pull, so the first assumption always holds. The device only pulls the line after the master has released it, and always releases it before the receiver samples the stop bit. Random device answers are sized to cover at least one receiver sample point, so the expected presence and read bit are never in doubt.

// File: rtl/ow_uart_pkg.sv
// Shared types for the UART-timed 1-Wire master.
// Holds the command codes and the transmit patterns that shape each slot.
package ow_uart_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } ow_op_e;

    // Transmit bytes: their zero bits, after the start bit, set the low time
    localparam logic [7:0] PAT_RESET = 8'hF0;
    localparam logic [7:0] PAT_ZERO  = 8'h80;
    localparam logic [7:0] PAT_ONE   = 8'hFF;

    // Picks the transmit byte for a command
    function automatic logic [7:0] slot_pattern(input ow_op_e op, input logic wbit);
        logic [7:0] pat;
        case (op)
            OP_RESET: pat = PAT_RESET;
            OP_WRITE: pat = wbit ? PAT_ONE : PAT_ZERO;
            default:  pat = PAT_ONE;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/ow_baud_gen.sv
// Oversampling tick generator with two selectable divisors.
// Assumes both divisors are at least 1. The restart input clears the phase,
// so every frame begins on a fresh tick grid. use_slow must only change in a
// cycle in which restart is high.
module ow_baud_gen #(
    parameter int DIV_SLOW = 325,
    parameter int DIV_FAST = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_slow,
    input  logic restart,
    output logic tick
);
    localparam int MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW      = $clog2(MAX_DIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Terminal count for the selected rate
    always_comb limit = use_slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);

    // Tick on terminal count, suppressed while restarting
    always_comb tick = !restart && (cnt == limit);

    // Phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ow_uart_tx.sv
// 8N1 transmitter driving an open-drain pull-low output.
// Sends a low start bit, eight data bits LSB first, and a high stop bit.
// Each bit lasts OVS ticks. Assumes OVS is a power of two and that start
// is only raised while the transmitter is idle.
module ow_uart_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       tick,
    output logic       line_low,
    output logic       frame_done
);
    localparam int TW = $clog2(OVS);

    logic          busy;
    logic [9:0]    frame;
    logic [TW-1:0] tcnt;
    logic [3:0]    bidx;

    // Load, then shift one bit per OVS ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            frame      <= '1;
            tcnt       <= '0;
            bidx       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                frame <= {1'b1, data, 1'b0};
                tcnt  <= '0;
                bidx  <= '0;
            end else if (busy && tick) begin
                if (tcnt == TW'(OVS - 1)) begin
                    tcnt  <= '0;
                    frame <= {1'b1, frame[9:1]};
                    if (bidx == 4'd9) begin
                        busy       <= 1'b0;
                        frame_done <= 1'b1;
                    end else begin
                        bidx <= bidx + 4'd1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    // Pull low only for a zero bit of a live frame
    always_comb line_low = busy && !frame[0];
endmodule

// File: rtl/ow_uart_rx.sv
// 8N1 receiver with mid-bit sampling by oversampling ticks.
// Listens only while armed. A falling edge starts a frame, the start bit is
// checked half a bit later, and then data and stop are sampled once per bit.
// Assumes SYNC >= 2 and OVS a power of two.
module ow_uart_rx #(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       arm,
    input  logic       tick,
    output logic [7:0] data_out,
    output logic       valid
);
    localparam int TW = $clog2(OVS);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    rx_state_e     st;
    logic [SYNC-1:0] sy;
    logic          level;
    logic          prev;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;

    // Input synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) sy <= '1;
        else        sy <= {sy[SYNC-2:0], line_in};
    end

    always_comb level = sy[SYNC-1];

    // Frame recognition and bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            prev     <= 1'b1;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            data_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            prev  <= level;
            if (!arm) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        if (prev && !level) begin
                            st   <= RX_START;
                            tcnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick) begin
                            if (tcnt == TW'(OVS / 2 - 1)) begin
                                tcnt <= '0;
                                bidx <= '0;
                                st   <= level ? RX_IDLE : RX_DATA;
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (tick) begin
                            if (tcnt == TW'(OVS - 1)) begin
                                tcnt  <= '0;
                                shreg <= {level, shreg[7:1]};
                                if (bidx == 3'd7) st <= RX_STOP;
                                else              bidx <= bidx + 3'd1;
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (tick) begin
                            if (tcnt == TW'(OVS - 1)) begin
                                tcnt     <= '0;
                                data_out <= shreg;
                                valid    <= 1'b1;
                                st       <= RX_IDLE;
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ow_uart_master.sv
// 1-Wire master that times every slot with one UART frame.
// Accepts reset, write-bit and read-bit commands while idle. It selects the
// baud rate and transmit byte, sends the frame open-drain, captures the echo
// and decodes presence or the bus bit, then pulses done. Assumes bus_sense
// is the wired-AND of the master drive and all devices.
module ow_uart_master #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SLOW_BAUD = 9600,
    parameter int FAST_BAUD = 115200,
    parameter int OVS       = 16,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    output logic       cmd_ready,
    output logic       bus_pull_low,
    input  logic       bus_sense,
    output logic       done,
    output logic       presence,
    output logic       result_bit
);
    import ow_uart_pkg::*;

    localparam int DIV_SLOW      = CLK_HZ / (SLOW_BAUD * OVS);
    localparam int DIV_FAST      = CLK_HZ / (FAST_BAUD * OVS);
    localparam int RESET_LOW_CYC = 5 * OVS * DIV_SLOW;

    typedef enum logic {ST_IDLE, ST_BUSY} ctl_state_e;

    ctl_state_e state;
    ow_op_e     op_in;
    ow_op_e     op_q;
    logic       accept;
    logic       slow_q;
    logic [7:0] echo_q;
    logic       tick;
    logic       tx_done;
    logic [7:0] rx_data;
    logic       rx_valid;

    // Decode the incoming command
    always_comb begin
        op_in  = ow_op_e'(cmd_op);
        accept = cmd_valid && (state == ST_IDLE) && (op_in != OP_RSVD);
    end

    // Command sequencing and result decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_q       <= OP_RESET;
            slow_q     <= 1'b0;
            echo_q     <= '0;
            done       <= 1'b0;
            presence   <= 1'b0;
            result_bit <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state  <= ST_BUSY;
                op_q   <= op_in;
                slow_q <= (op_in == OP_RESET);
                echo_q <= '0;
            end else if (state == ST_BUSY) begin
                if (rx_valid) echo_q <= rx_data;
                if (tx_done) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    if (op_q == OP_RESET) presence   <= (echo_q != PAT_RESET);
                    else                  result_bit <= (echo_q == PAT_ONE);
                end
            end
        end
    end

    always_comb cmd_ready = (state == ST_IDLE);

    ow_baud_gen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_slow (accept ? (op_in == OP_RESET) : slow_q),
        .restart  (accept),
        .tick     (tick)
    );

    ow_uart_tx #(
        .OVS (OVS)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .data       (slot_pattern(op_in, cmd_bit)),
        .tick       (tick),
        .line_low   (bus_pull_low),
        .frame_done (tx_done)
    );

    ow_uart_rx #(
        .OVS  (OVS),
        .SYNC (SYNC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (bus_sense),
        .arm      (state == ST_BUSY),
        .tick     (tick),
        .data_out (rx_data),
        .valid    (rx_valid)
    );
endmodule

// File: rtl/ow_uart_master_chk.sv
// Protocol checker for ow_uart_master, attached by bind.
// Assumes the reset and command inputs are driven to known values.
module ow_uart_master_chk #(
    parameter int MAX_LOW = 26000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_ready,
    input logic       bus_pull_low,
    input logic       done
);
    int unsigned low_run;

    // Length of the current pull-low run, in cycles before this one
    always_ff @(posedge clk) begin
        if (!rst_n)            low_run <= 0;
        else if (bus_pull_low) low_run <= low_run + 1;
        else                   low_run <= 0;
    end

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_pull_low);

    p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low |-> (low_run < MAX_LOW));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 2'b11) |=> !cmd_ready);

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!cmd_ready));

    p_rsvd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> (cmd_ready && !bus_pull_low));
endmodule

bind ow_uart_master ow_uart_master_chk #(
    .MAX_LOW (RESET_LOW_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ready    (cmd_ready),
    .bus_pull_low (bus_pull_low),
    .done         (done)
);

// File: tb/test_ow_uart_master.sv
// Self-checking bench: directed corner cases plus seeded random slots,
// with a modelled device sharing the open-drain line.
module test_ow_uart_master;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 3_686_400;
    localparam int SLOW_BAUD  = 9600;
    localparam int FAST_BAUD  = 115200;
    localparam int OVS        = 16;
    localparam int DS         = CLK_HZ / (SLOW_BAUD * OVS);
    localparam int DF         = CLK_HZ / (FAST_BAUD * OVS);
    localparam int BIT_S      = OVS * DS;
    localparam int BIT_F      = OVS * DF;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_bit = 1'b0;
    logic       cmd_ready;
    logic       bus_pull_low;
    logic       bus_sense;
    logic       done;
    logic       presence;
    logic       result_bit;
    logic       dev_pull = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int r_low;
    int r_lat;
    bit r_pres;
    bit r_bit;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Wired-AND bus: master and device can both pull low
    assign bus_sense = ~(bus_pull_low | dev_pull);

    ow_uart_master #(
        .CLK_HZ    (CLK_HZ),
        .SLOW_BAUD (SLOW_BAUD),
        .FAST_BAUD (FAST_BAUD),
        .OVS       (OVS),
        .SYNC      (2)
    ) i_ow_uart_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bit      (cmd_bit),
        .cmd_ready    (cmd_ready),
        .bus_pull_low (bus_pull_low),
        .bus_sense    (bus_sense),
        .done         (done),
        .presence     (presence),
        .result_bit   (result_bit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected pull-low length of a slot
    function automatic int exp_low(input int op, input bit wbit);
        if (op == 0)              return 5 * BIT_S;
        if (op == 1 && !wbit)     return 8 * BIT_F;
        return BIT_F;
    endfunction

    // Expected result bit of a read or write slot
    function automatic bit exp_bit(input int op, input bit wbit, input bit dev_on);
        if (op == 2) return !dev_on;
        return wbit;
    endfunction

    // Issue one slot, run the device model, capture timing and results
    task automatic run_slot(input int op, input bit wbit, input bit dev_on,
                            input int dev_wait, input int dev_len, input bit poke);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op[1:0];
        cmd_bit   = wbit;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        fork
            begin
                r_low = 0;
                while (bus_pull_low) begin
                    r_low++;
                    @(negedge clk);
                end
                if (dev_on) begin
                    repeat (dev_wait) @(negedge clk);
                    dev_pull = 1'b1;
                    repeat (dev_len) @(negedge clk);
                    dev_pull = 1'b0;
                end
            end
            begin
                r_lat = 1;
                while (!done) begin
                    @(negedge clk);
                    r_lat++;
                end
                r_pres = presence;
                r_bit  = result_bit;
                chk(cmd_ready == 1'b1, "R7", "ready with done", int'(cmd_ready), 1);
                @(negedge clk);
                chk(done == 1'b0, "R7", "done single cycle", int'(done), 0);
            end
            begin
                if (poke) begin
                    repeat (20) @(negedge clk);
                    cmd_valid = 1'b1;
                    cmd_op    = 2'b00;
                    @(negedge clk);
                    cmd_valid = 1'b0;
                end
            end
        join
    endtask

    // Run a slot and check every observable result against the requirements
    task automatic slot_checked(input int op, input bit wbit, input bit dev_on, input bit poke);
        int wait_c;
        int len_c;
        int frame;
        wait_c = 0;
        len_c  = 0;
        if (op == 0) begin
            wait_c = $urandom_range(BIT_S / 4, BIT_S);
            len_c  = $urandom_range(BIT_S + 8, 2 * BIT_S);
        end else begin
            len_c  = $urandom_range(BIT_F, 6 * BIT_F);
        end
        run_slot(op, wbit, dev_on, wait_c, len_c, poke);
        frame = 10 * ((op == 0) ? BIT_S : BIT_F);
        if (op == 0)
            chk(r_low == exp_low(op, wbit), "R2", "reset low time", r_low, exp_low(op, wbit));
        else if (op == 1 && !wbit)
            chk(r_low == exp_low(op, wbit), "R4", "write0 low time", r_low, exp_low(op, wbit));
        else
            chk(r_low == exp_low(op, wbit), "R5", "short slot low time", r_low, exp_low(op, wbit));
        chk(r_lat >= frame && r_lat <= frame + 3, "R7", "done latency", r_lat, frame);
        if (op == 0)
            chk(r_pres == dev_on, "R3", "presence", int'(r_pres), int'(dev_on));
        else
            chk(r_bit == exp_bit(op, wbit, dev_on), "R6", "result bit",
                int'(r_bit), int'(exp_bit(op, wbit, dev_on)));
    endtask

    // After an ignored command the line and done must stay quiet
    task automatic quiet_window(input string what);
        bit seen_low;
        bit seen_done;
        bit seen_busy;
        seen_low  = 1'b0;
        seen_done = 1'b0;
        seen_busy = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (bus_pull_low) seen_low = 1'b1;
            if (done)         seen_done = 1'b1;
            if (!cmd_ready)   seen_busy = 1'b1;
        end
        chk(!seen_low,  "R8", {what, " line quiet"}, int'(seen_low), 0);
        chk(!seen_done, "R8", {what, " no done"},    int'(seen_done), 0);
        chk(!seen_busy, "R8", {what, " ready held"}, int'(seen_busy), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        chk(cmd_ready == 1'b1,    "R1", "ready in reset",   int'(cmd_ready), 1);
        chk(bus_pull_low == 1'b0, "R1", "line in reset",    int'(bus_pull_low), 0);
        chk(done == 1'b0,         "R1", "done in reset",    int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1 && bus_pull_low == 1'b0, "R1", "idle after reset",
            int'({cmd_ready, bus_pull_low}), 2);

        // Directed corner cases
        slot_checked(0, 1'b0, 1'b0, 1'b0);   // R3 no device
        slot_checked(0, 1'b0, 1'b1, 1'b0);   // R3 device present
        slot_checked(1, 1'b0, 1'b0, 1'b0);   // R4 write 0
        slot_checked(1, 1'b1, 1'b0, 1'b0);   // R5 write 1
        slot_checked(2, 1'b0, 1'b1, 1'b0);   // R6 read 0
        slot_checked(2, 1'b0, 1'b0, 1'b0);   // R6 read 1
        // R9: rate switches back to back
        slot_checked(2, 1'b0, 1'b0, 1'b0);
        slot_checked(0, 1'b0, 1'b1, 1'b0);
        slot_checked(1, 1'b0, 1'b0, 1'b0);
        chk(r_low == 8 * BIT_F, "R9", "fast after slow", r_low, 8 * BIT_F);
        slot_checked(0, 1'b0, 1'b0, 1'b0);
        chk(r_low == 5 * BIT_S, "R9", "slow after fast", r_low, 5 * BIT_S);

        // R8: command while busy is dropped
        slot_checked(2, 1'b0, 1'b1, 1'b1);
        quiet_window("busy command");

        // R8: reserved op code is dropped
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'b11;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        quiet_window("reserved op");

        // Seeded random mix
        for (int i = 0; i < 30; i++) begin
            int op;
            bit wb;
            bit dv;
            op = $urandom_range(0, 2);
            wb = 1'($urandom_range(0, 1));
            dv = (op == 1) ? 1'b0 : 1'($urandom_range(0, 1));
            slot_checked(op, wb, dv, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule